// File: doc/BRIEF.md
# Reset Cause Arbiter and Reset-Mode Vector Generator

This block sits beside one processor core and decides which reset the core takes when several causes compete. It watches four sources: a power-on request, an external reset pin, a software reset request raised by the local core, and a watchdog condition. The block creates the watchdog condition itself when a trap is taken while its own trap-level counter already stands at the maximum level. For the winning cause it produces a trap type, a virtual fetch address inside the reset-mode vector region, and the matching physical address. It marks the result with a single-cycle valid strobe.

The block keeps the core's trap level. A taken trap raises the level and a trap return lowers it. A watchdog event also latches an error-state flag, which stays set until a reset that reaches the whole system. A separate strobe shows whether the accepted reset is of the system-wide kind (power-on or external) or is local to this core (software or watchdog).

Top module: `rstvec_arb`

## Requirements
- R1: Causes are ranked power-on, external, watchdog, software. Only the top-ranked request present in a cycle is accepted and the others in that cycle are dropped. Trap type codes are 0x01 for power-on, 0x02 for watchdog, 0x03 for external and 0x04 for software.
- R2: The virtual vector address is 0xFFFF_FFFF_F000_0000 plus the trap type times 0x20. That gives offsets 0x20, 0x40, 0x60 and 0x80.
- R3: The 41-bit physical vector address equals the low 41 bits of the virtual vector address, that is 0x1FF_F000_0000 plus the same offset.
- R4: `vec_valid_o` is high for exactly the one cycle after a cycle in which a request was accepted. The trap type and both addresses are registered with it and hold their values until the next accepted request.
- R5: A trap taken while the trap level equals MAX_TL raises a watchdog request in the same cycle and sets `err_state_o` from the next cycle on.
- R6: `err_state_o` is cleared only by a power-on or external request. Software requests, watchdog requests, traps and returns leave a set flag set.
- R7: With no request accepted, a trap below MAX_TL raises the trap level by one. A return with no trap lowers it by one and saturates at 0. When a trap and a return arrive in the same cycle, the trap wins.
- R8: Every accepted request sets the trap level to MAX_TL in the next cycle.
- R9: `sys_rst_o` pulses together with `vec_valid_o` only for power-on and external requests. It stays low for software and watchdog requests.
- R10: While `rst_ni` is low, the outputs are: valid 0, trap type 0, both addresses 0, error flag 0, system strobe 0, and trap level MAX_TL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| por_req_i | input | 1 | Power-on reset request |
| ext_req_i | input | 1 | External reset pin request |
| sw_req_i | input | 1 | Software reset request from the local core |
| trap_i | input | 1 | Trap-taken strobe |
| ret_i | input | 1 | Trap-return strobe |
| vec_valid_o | output | 1 | One-cycle strobe for an accepted reset |
| vec_tt_o | output | 8 | Trap type of the last accepted reset |
| vec_va_o | output | 64 | Virtual vector address |
| vec_pa_o | output | 41 | Physical vector address |
| err_state_o | output | 1 | Error-state flag |
| sys_rst_o | output | 1 | Accepted reset is system-wide |
| tl_o | output | $clog2(MAX_TL+1) | Current trap level |

## Verification
Every combination of the five request and trap strobes is applied at every trap level from 0 to MAX_TL. The trap level is set up beforehand with an external reset followed by returns. The combinations that differ only in lower-ranked bits show whether ranking and dropping work. The same trap applied below and at MAX_TL separates a plain level increment from a watchdog entry. Cycles with nothing asserted, and the software-reset cycles that follow a watchdog, show that the vector outputs hold and that the error flag survives everything except power-on and external requests.

// File: rtl/rstvec_pkg.sv
package rstvec_pkg;

  localparam int TT_W   = 8;
  localparam int VA_W   = 64;
  localparam int PA_W   = 41;
  localparam int OFS_SH = 5;

  typedef enum logic [TT_W-1:0] {
    CAUSE_NONE = 8'h00,
    CAUSE_POR  = 8'h01,
    CAUSE_WDR  = 8'h02,
    CAUSE_XIR  = 8'h03,
    CAUSE_SIR  = 8'h04
  } cause_e;

  // offset of a cause inside the vector region
  function automatic logic [VA_W-1:0] vec_offset(input logic [TT_W-1:0] tt);
    logic [VA_W-1:0] w;
    w = {{(VA_W-TT_W){1'b0}}, tt};
    return w << OFS_SH;
  endfunction

  function automatic logic [VA_W-1:0] vec_va(input logic [VA_W-1:0] base,
                                             input logic [TT_W-1:0] tt);
    return base + vec_offset(tt);
  endfunction

  // identity translation: the region passes straight through
  function automatic logic [PA_W-1:0] va_to_pa(input logic [VA_W-1:0] va);
    return va[PA_W-1:0];
  endfunction

  function automatic logic is_system_cause(input cause_e c);
    return (c == CAUSE_POR) || (c == CAUSE_XIR);
  endfunction

endpackage

// File: rtl/rstvec_prio.sv
module rstvec_prio
  import rstvec_pkg::*;
(
  input  logic   por_i,
  input  logic   ext_i,
  input  logic   wdr_i,
  input  logic   sw_i,
  output cause_e cause_o,
  output logic   take_o
);
  localparam int N_SRC = 4;

  logic   [N_SRC-1:0] req;
  cause_e             code [N_SRC];

  // index 0 is the highest rank
  assign req     = {sw_i, wdr_i, ext_i, por_i};
  assign code[0] = CAUSE_POR;
  assign code[1] = CAUSE_XIR;
  assign code[2] = CAUSE_WDR;
  assign code[3] = CAUSE_SIR;

  always_comb begin
    cause_o = CAUSE_NONE;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) cause_o = code[i];
    end
  end

  assign take_o = |req;
endmodule

// File: rtl/rstvec_tlctr.sv
module rstvec_tlctr #(
  parameter int MAX_TL = 5,
  localparam int TLW   = $clog2(MAX_TL + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           trap_i,
  input  logic           ret_i,
  input  logic           load_max_i,
  output logic [TLW-1:0] tl_o,
  output logic           at_max_o
);
  localparam logic [TLW-1:0] TL_TOP = TLW'(MAX_TL);

  logic [TLW-1:0] tl_q, tl_d;

  always_comb begin
    tl_d = tl_q;
    if (load_max_i) begin
      tl_d = TL_TOP;
    end else if (trap_i) begin
      if (tl_q != TL_TOP) tl_d = tl_q + 1'b1;
    end else if (ret_i) begin
      if (tl_q != '0) tl_d = tl_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tl_q <= TL_TOP;
    else         tl_q <= tl_d;
  end

  assign tl_o     = tl_q;
  assign at_max_o = (tl_q == TL_TOP);
endmodule

// File: rtl/rstvec_vecreg.sv
module rstvec_vecreg
  import rstvec_pkg::*;
#(
  parameter logic [VA_W-1:0] VEC_BASE = 64'hFFFF_FFFF_F000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  cause_e          cause_i,
  output logic            valid_o,
  output logic [TT_W-1:0] tt_o,
  output logic [VA_W-1:0] va_o,
  output logic [PA_W-1:0] pa_o,
  output logic            sys_o
);
  logic [VA_W-1:0] va_d;

  assign va_d = vec_va(VEC_BASE, cause_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sys_o   <= 1'b0;
      tt_o    <= '0;
      va_o    <= '0;
      pa_o    <= '0;
    end else begin
      valid_o <= take_i;
      sys_o   <= take_i && is_system_cause(cause_i);
      if (take_i) begin
        tt_o <= cause_i;
        va_o <= va_d;
        pa_o <= va_to_pa(va_d);
      end
    end
  end
endmodule

// File: rtl/rstvec_arb.sv
module rstvec_arb
  import rstvec_pkg::*;
#(
  parameter int MAX_TL = 5,
  parameter logic [63:0] VEC_BASE = 64'hFFFF_FFFF_F000_0000,
  localparam int TLW = $clog2(MAX_TL + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           por_req_i,
  input  logic           ext_req_i,
  input  logic           sw_req_i,
  input  logic           trap_i,
  input  logic           ret_i,
  output logic           vec_valid_o,
  output logic [7:0]     vec_tt_o,
  output logic [63:0]    vec_va_o,
  output logic [40:0]    vec_pa_o,
  output logic           err_state_o,
  output logic           sys_rst_o,
  output logic [TLW-1:0] tl_o
);
  // named internal events
  logic   wdr_evt;
  logic   sys_evt;
  logic   acc_evt;
  logic   tl_at_max;
  cause_e win_cause;
  logic   err_q;

  assign wdr_evt = trap_i && tl_at_max;
  assign sys_evt = por_req_i || ext_req_i;

  rstvec_prio u_prio (
    .por_i   (por_req_i),
    .ext_i   (ext_req_i),
    .wdr_i   (wdr_evt),
    .sw_i    (sw_req_i),
    .cause_o (win_cause),
    .take_o  (acc_evt)
  );

  rstvec_tlctr #(.MAX_TL(MAX_TL)) u_tl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trap_i     (trap_i),
    .ret_i      (ret_i),
    .load_max_i (acc_evt),
    .tl_o       (tl_o),
    .at_max_o   (tl_at_max)
  );

  rstvec_vecreg #(.VEC_BASE(VEC_BASE)) u_vec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (acc_evt),
    .cause_i (win_cause),
    .valid_o (vec_valid_o),
    .tt_o    (vec_tt_o),
    .va_o    (vec_va_o),
    .pa_o    (vec_pa_o),
    .sys_o   (sys_rst_o)
  );

  // system-wide reset clears the flag; a watchdog sets it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (sys_evt) err_q <= 1'b0;
    else if (wdr_evt) err_q <= 1'b1;
  end

  assign err_state_o = err_q;
endmodule

// File: rtl/rstvec_arb_chk.sv
module rstvec_arb_chk #(
  parameter int MAX_TL = 5,
  parameter logic [63:0] VEC_BASE = 64'hFFFF_FFFF_F000_0000,
  localparam int TLW = $clog2(MAX_TL + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           por_req_i,
  input logic           ext_req_i,
  input logic           sw_req_i,
  input logic           trap_i,
  input logic           ret_i,
  input logic           vec_valid_o,
  input logic [7:0]     vec_tt_o,
  input logic [63:0]    vec_va_o,
  input logic [40:0]    vec_pa_o,
  input logic           err_state_o,
  input logic           sys_rst_o,
  input logic [TLW-1:0] tl_o
);
  localparam logic [TLW-1:0] TOP = TLW'(MAX_TL);

  logic any_req;
  assign any_req = por_req_i || ext_req_i || sw_req_i || (trap_i && tl_o == TOP);

  p_por_wins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_req_i |=> vec_tt_o == 8'h01);
  p_ext_second_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_req_i && ext_req_i) |=> vec_tt_o == 8'h03);
  p_va_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> vec_va_o == VEC_BASE + {51'd0, vec_tt_o, 5'd0});
  p_pa_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> vec_pa_o == vec_va_o[40:0]);
  p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |=> vec_valid_o);
  p_valid_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_req |=> !vec_valid_o);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> $stable(vec_va_o) && $stable(vec_tt_o));
  p_err_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && tl_o == TOP && !por_req_i && !ext_req_i) |=> err_state_o);
  p_err_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_state_o && !por_req_i && !ext_req_i) |=> err_state_o);
  p_tl_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tl_o <= TOP);
  p_tl_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |=> tl_o == TOP);
  p_sys_kind_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> vec_valid_o && (vec_tt_o == 8'h01 || vec_tt_o == 8'h03));
endmodule

bind rstvec_arb rstvec_arb_chk #(.MAX_TL(MAX_TL), .VEC_BASE(VEC_BASE)) u_chk (.*);

// File: tb/rstvec_arb_tb.sv
module rstvec_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXL = 5;
  localparam int TLW = $clog2(MAXL + 1);
  localparam logic [63:0] BASE = 64'hFFFF_FFFF_F000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 0, ext = 0, sw = 0, trap = 0, ret = 0;
  logic vld, err, sys;
  logic [7:0] tt;
  logic [63:0] va;
  logic [40:0] pa;
  logic [TLW-1:0] tl;

  int total = 0, bad = 0;
  bit done = 0;

  // bench-side expectation
  int m_tl, m_err, m_vld, m_sys, m_tt;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstvec_arb #(.MAX_TL(MAXL), .VEC_BASE(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_req_i(por), .ext_req_i(ext),
    .sw_req_i(sw), .trap_i(trap), .ret_i(ret), .vec_valid_o(vld),
    .vec_tt_o(tt), .vec_va_o(va), .vec_pa_o(pa), .err_state_o(err),
    .sys_rst_o(sys), .tl_o(tl));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [63:0] eva;
    eva = BASE + 64'(m_tt) * 64'h20;
    chk("R1 trap type", {56'd0, tt}, 64'(m_tt));
    chk("R2 virtual vector", va, (m_tt == 0) ? 64'd0 : eva);
    chk("R3 physical vector", {23'd0, pa}, (m_tt == 0) ? 64'd0 : {23'd0, eva[40:0]});
    chk("R4 valid strobe", {63'd0, vld}, 64'(m_vld));
    chk("R5 R6 error flag", {63'd0, err}, 64'(m_err));
    chk("R7 R8 trap level", 64'(tl), 64'(m_tl));
    chk("R9 system strobe", {63'd0, sys}, 64'(m_sys));
  endtask

  // one cycle: drive at a falling edge, compare at the next falling edge
  task automatic apply(input logic p, input logic e, input logic s,
                       input logic t, input logic r);
    int code;
    bit wd;
    por = p; ext = e; sw = s; trap = t; ret = r;
    wd = t && (m_tl == MAXL);
    code = p ? 1 : e ? 3 : wd ? 2 : s ? 4 : 0;
    if (p || e) m_err = 0;
    else if (wd) m_err = 1;
    m_vld = (code != 0);
    m_sys = (p || e);
    if (code != 0) begin
      m_tt = code;
      m_tl = MAXL;
    end else if (t) begin
      if (m_tl < MAXL) m_tl++;
    end else if (r) begin
      if (m_tl > 0) m_tl--;
    end
    @(negedge clk);
    por = 0; ext = 0; sw = 0; trap = 0; ret = 0;
    check_all();
  endtask

  initial begin
    m_tl = MAXL; m_err = 0; m_vld = 0; m_sys = 0; m_tt = 0;
    repeat (3) @(negedge clk);
    check_all(); // R10 values held in reset
    rst_n = 1'b1;
    @(negedge clk);
    check_all(); // R10 after release
    // full sweep: every strobe combination at every trap level
    for (int lvl = 0; lvl <= MAXL; lvl++) begin
      for (int c = 0; c < 32; c++) begin
        apply(0, 1, 0, 0, 0);
        for (int k = 0; k < MAXL - lvl; k++) apply(0, 0, 0, 0, 1);
        apply(c[0], c[1], c[2], c[3], c[4]);
        apply(0, 0, 0, 0, 0); // R4 hold with nothing asserted
      end
    end
    // R6: watchdog, then software and idle keep the flag, external clears it
    apply(0, 0, 0, 1, 0);
    apply(0, 0, 1, 0, 0);
    apply(0, 0, 0, 0, 1);
    apply(0, 0, 0, 1, 0);
    apply(0, 1, 0, 0, 0);
    // R7: return at 0 saturates
    for (int k = 0; k < MAXL + 2; k++) apply(0, 0, 0, 0, 1);
    // R7: climb to the top, then one more trap is a watchdog
    for (int k = 0; k < MAXL + 1; k++) apply(0, 0, 0, 1, 0);
    apply(1, 0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule